// File: doc/BRIEF.md
# SRAM Controller with Sub-Word Writes

This block fronts a single-port on-chip storage array with a simple request/ready bus. A requester presents a valid request with an address, a write flag, a size code and write data. The controller answers through a ready strobe, an error strobe and a read-data word. Full-word reads and writes finish in the same cycle they are presented. Byte and halfword writes normally finish in the same cycle as well, by enabling only the affected byte lanes of the array.

There is one exception. If a byte or halfword write comes in the cycle directly after a completed read that hit the same memory block, the controller lowers ready for one cycle. In that cycle it captures the old word. In the following cycle it writes back the old word merged with the new bytes. A block is the group of addresses that share every address bit above a configurable block-size boundary.

The array is a parameterised register array of 32-bit words, sized up to 20 KB. Requests that are misaligned, that use the reserved size code, or that fall outside the array are refused with a one-cycle error response.

Top module: `sram_ctrl`

## Requirements
- R1: A read (req_write=0, size 10) that is aligned and in range completes in the cycle it is presented. rsp_ready is 1 in that cycle, and rsp_rdata holds the stored word at word index req_addr[ADDR_W-1:2].
- R2: A 32-bit write (size 10) completes with zero wait states, including directly after a read to the same block. The word is stored at the clock edge that ends the cycle.
- R3: The size code is 00 for a byte, 01 for a halfword and 10 for a word. Lanes are numbered little-endian: byte k is req_wdata[8k+7:8k], selected by req_addr[1:0]. A halfword uses lanes 1:0 when req_addr[1]=0 and lanes 3:2 when req_addr[1]=1. A narrow write changes only its selected lanes.
- R4: A byte or halfword write presented in the cycle right after a completed, error-free read to the same block sees rsp_ready=0 for exactly one cycle and rsp_ready=1 in the next cycle. The stored word is then the old word with the new lanes merged in. The request must stay stable while rsp_ready is 0.
- R5: A byte or halfword write that does not directly follow a completed same-block read completes with zero wait states. This covers a read to another block, an idle cycle in between, or a preceding write.
- R6: A request that is misaligned (halfword with req_addr[0]=1, word with req_addr[1:0]!=0), uses size 11, or addresses word index DEPTH_WORDS or above gets rsp_ready=1 and rsp_error=1 in the same cycle. Such a request changes no stored word, and rsp_rdata is 0.
- R7: rsp_rdata is 0 in every cycle that is not completing an error-free read, including idle cycles and wait-state cycles.
- R8: During and after reset with no request, rsp_ready, rsp_error and rsp_rdata are 0. Reset clears the read history, so a narrow write in the first cycle after reset does not stall, even if a read was presented during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, each byte on its own lane |
| rsp_ready | output | 1 | Request completes this cycle |
| rsp_error | output | 1 | Request refused this cycle (with rsp_ready) |
| rsp_rdata | output | 32 | Read word, 0 unless a read completes |

## Verification
The stimulus walks word writes, byte writes on every lane and halfword writes on both halves, each followed by a read-back. These read-backs catch a wrong lane mapping or a merge that clobbers a neighbouring byte. The same narrow writes are placed directly after a same-block read, after an other-block read, after an idle cycle and after another write. This separates a missing stall, a stall that lasts two cycles and a stall that fires when it should not. Misaligned, reserved-size and out-of-range requests are each followed by a read of the word they would have hit, which exposes a refused write that still lands. A read presented during reset, followed by a narrow write right after release, shows whether reset clears the read history.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_MERGE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DEPTH_WORDS = 512,
    parameter int BLK_BITS    = 8,
    localparam int IDX_W      = $clog2(DEPTH_WORDS),
    localparam int BLK_W      = ADDR_W - BLK_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              bad,
    output logic [IDX_W-1:0]  widx,
    output logic [BLK_W-1:0]  blk
);
    localparam int WNO_W = ADDR_W - 2;
    localparam logic [WNO_W:0] LIMIT = (WNO_W + 1)'(DEPTH_WORDS);

    logic [WNO_W-1:0] word_no;
    logic             misalign;
    logic             in_range;

    always_comb begin
        word_no  = addr[ADDR_W-1:2];
        in_range = ({1'b0, word_no} < LIMIT);
        unique case (acc_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = addr[0];
            SZ_WORD: misalign = (addr[1:0] != 2'b00);
            default: misalign = 1'b1;
        endcase
        bad  = misalign || !in_range;
        widx = word_no[IDX_W-1:0];
        blk  = addr[ADDR_W-1:BLK_BITS];
    end

endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge
    import sram_ctrl_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: be = LANES'(1) << addr_lo;
            SZ_HALF: be = addr_lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: be = '1;
            default: be = '0;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = be[g] ? new_word[g*LANE_W +: LANE_W]
                                                  : old_word[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sram_bank_array.sv
module sram_bank_array
    import sram_ctrl_pkg::*;
#(
    parameter int DEPTH_WORDS = 512,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wword,
    output logic [DATA_W-1:0] rword
);
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH_WORDS];

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                bank[widx] <= wword[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = bank[widx];
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DEPTH_WORDS = 512,
    parameter int BLK_BITS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic              rsp_error,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W = $clog2(DEPTH_WORDS);
    localparam int BLK_W = ADDR_W - BLK_BITS;

    typedef struct packed {
        ctl_state_e        st;
        logic              rd_seen;
        logic [BLK_W-1:0]  rd_blk;
        logic [DATA_W-1:0] hold;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              dec_bad;
    logic [IDX_W-1:0]  dec_widx;
    logic [BLK_W-1:0]  dec_blk;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] merged_word;
    logic [DATA_W-1:0] arr_rword;
    logic              arr_we;
    logic [LANES-1:0]  arr_be;
    logic [DATA_W-1:0] arr_wword;
    logic              narrow;

    sram_addr_decode #(
        .ADDR_W     (ADDR_W),
        .DEPTH_WORDS(DEPTH_WORDS),
        .BLK_BITS   (BLK_BITS)
    ) u_dec (
        .addr(req_addr),
        .size(req_size),
        .bad (dec_bad),
        .widx(dec_widx),
        .blk (dec_blk)
    );

    sram_lane_merge u_merge (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .old_word(c_q.hold),
        .new_word(req_wdata),
        .be      (lane_be),
        .merged  (merged_word)
    );

    sram_bank_array #(
        .DEPTH_WORDS(DEPTH_WORDS)
    ) u_arr (
        .clk  (clk),
        .we   (arr_we),
        .be   (arr_be),
        .widx (dec_widx),
        .wword(arr_wword),
        .rword(arr_rword)
    );

    always_comb begin
        c_d       = c_q;
        rsp_ready = 1'b0;
        rsp_error = 1'b0;
        rsp_rdata = '0;
        arr_we    = 1'b0;
        arr_be    = '0;
        arr_wword = '0;
        narrow    = (acc_size_e'(req_size) == SZ_BYTE) ||
                    (acc_size_e'(req_size) == SZ_HALF);

        unique case (c_q.st)
            ST_MERGE: begin
                c_d.st      = ST_RUN;
                c_d.rd_seen = 1'b0;
                if (req_valid) begin
                    rsp_ready = 1'b1;
                    arr_we    = 1'b1;
                    arr_be    = '1;
                    arr_wword = merged_word;
                end
            end
            default: begin
                c_d.rd_seen = 1'b0;
                if (req_valid) begin
                    if (dec_bad) begin
                        rsp_ready = 1'b1;
                        rsp_error = 1'b1;
                    end else if (!req_write) begin
                        rsp_ready   = 1'b1;
                        rsp_rdata   = arr_rword;
                        c_d.rd_seen = 1'b1;
                        c_d.rd_blk  = dec_blk;
                    end else if (narrow && c_q.rd_seen && (c_q.rd_blk == dec_blk)) begin
                        c_d.st   = ST_MERGE;
                        c_d.hold = arr_rword;
                    end else begin
                        rsp_ready = 1'b1;
                        arr_we    = 1'b1;
                        arr_be    = lane_be;
                        arr_wword = req_wdata;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st      <= ST_RUN;
            c_q.rd_seen <= 1'b0;
            c_q.rd_blk  <= '0;
            c_q.hold    <= '0;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        rsp_ready,
    input logic        rsp_error,
    input logic [31:0] rsp_rdata
);
    assert_read_nowait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> rsp_ready);

    assert_word_write_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b10) |-> rsp_ready);

    // R3: only a byte or halfword write may ever be held
    assert_stall_only_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |-> (req_write && req_size[1] == 1'b0));

    assert_single_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |=> (req_valid && rsp_ready));

    assert_stall_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |->
            $past(req_valid && rsp_ready && !req_write && !rsp_error));

    assert_error_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_ready && rsp_rdata == 32'h0));

    assert_rdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && rsp_ready && !req_write) |-> (rsp_rdata == 32'h0));

endmodule

bind sram_ctrl sram_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_size (req_size),
    .rsp_ready(rsp_ready),
    .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

    localparam int PERIOD = 10;
    localparam int AW     = 12;

    typedef struct packed {
        logic          gap;
        logic          wr;
        logic [1:0]    sz;
        logic [AW-1:0] addr;
        logic [31:0]   wd;
        logic [2:0]    waits;
        logic          err;
        logic [31:0]   rd;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,2'b10,12'h000,32'h11223344,3'd0,1'b0,32'h0,        4'd2}, // R2
        '{1'b0,1'b1,2'b10,12'h100,32'hCAFEF00D,3'd0,1'b0,32'h0,        4'd2}, // R2
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h11223344, 4'd1}, // R1
        '{1'b0,1'b1,2'b00,12'h001,32'h0000AA00,3'd1,1'b0,32'h0,        4'd4}, // R4
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h1122AA44, 4'd3}, // R3
        '{1'b0,1'b1,2'b01,12'h002,32'hBEEF0000,3'd1,1'b0,32'h0,        4'd4}, // R4
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'hBEEFAA44, 4'd3}, // R3
        '{1'b0,1'b0,2'b10,12'h100,32'h0,       3'd0,1'b0,32'hCAFEF00D, 4'd1}, // R1
        '{1'b0,1'b1,2'b00,12'h003,32'h77000000,3'd0,1'b0,32'h0,        4'd5}, // R5 other block
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h77EFAA44, 4'd3}, // R3
        '{1'b1,1'b1,2'b00,12'h000,32'h00000055,3'd0,1'b0,32'h0,        4'd5}, // R5 idle gap
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h77EFAA55, 4'd3}, // R3
        '{1'b0,1'b1,2'b10,12'h004,32'h01020304,3'd0,1'b0,32'h0,        4'd2}, // R2 after same-block read
        '{1'b0,1'b1,2'b01,12'h005,32'hFFFFFFFF,3'd0,1'b1,32'h0,        4'd6}, // R6 misaligned half
        '{1'b0,1'b0,2'b10,12'h004,32'h0,       3'd0,1'b0,32'h01020304, 4'd6}, // R6 unchanged
        '{1'b0,1'b1,2'b11,12'h004,32'hFFFFFFFF,3'd0,1'b1,32'h0,        4'd6}, // R6 reserved size
        '{1'b0,1'b0,2'b10,12'h800,32'h0,       3'd0,1'b1,32'h0,        4'd6}, // R6 out of range
        '{1'b0,1'b0,2'b10,12'h004,32'h0,       3'd0,1'b0,32'h01020304, 4'd6}, // R6 unchanged
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h77EFAA55, 4'd1}, // R1
        '{1'b0,1'b1,2'b01,12'h000,32'h00009999,3'd1,1'b0,32'h0,        4'd4}, // R4 low half
        '{1'b0,1'b1,2'b00,12'h002,32'h00330000,3'd0,1'b0,32'h0,        4'd5}, // R5 after write
        '{1'b0,1'b0,2'b10,12'h000,32'h0,       3'd0,1'b0,32'h77339999, 4'd3}, // R3
        '{1'b0,1'b0,2'b10,12'h002,32'h0,       3'd0,1'b1,32'h0,        4'd6}  // R6 misaligned read
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'b10;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_ready;
    logic          rsp_error;
    logic [31:0]   rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DEPTH_WORDS(512), .BLK_BITS(8)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_size (req_size),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_ready(rsp_ready),
        .rsp_error(rsp_error),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_req(input vec_t v, input int idx);
        int waits;
        string tag;
        tag = $sformatf("R%0d vec%0d", v.rq, idx);
        if (v.gap) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(rsp_ready == 1'b0 && rsp_rdata == 32'h0, "R7 idle outputs",
                {31'h0, rsp_ready} | rsp_rdata, 32'h0);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = v.wr;
        req_size  = v.sz;
        req_addr  = v.addr;
        req_wdata = v.wd;
        waits = 0;
        #1;
        while (!rsp_ready && waits < 4) begin
            chk(rsp_rdata == 32'h0 && rsp_error == 1'b0, "R7 wait-cycle outputs",
                rsp_rdata, 32'h0);
            @(negedge clk);
            #1;
            waits++;
        end
        chk(waits == int'(v.waits), {tag, " wait states"}, 32'(waits), 32'(v.waits));
        chk(rsp_error == v.err, {tag, " error"}, {31'h0, rsp_error}, {31'h0, v.err});
        chk(rsp_rdata == v.rd, {tag, " rdata"}, rsp_rdata, v.rd);
        @(posedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: outputs quiet while held in reset
        repeat (3) @(negedge clk);
        #1;
        chk(rsp_ready == 1'b0 && rsp_error == 1'b0 && rsp_rdata == 32'h0,
            "R8 reset outputs", {30'h0, rsp_ready, rsp_error} | rsp_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rsp_ready == 1'b0 && rsp_rdata == 32'h0, "R8 idle after reset",
            {31'h0, rsp_ready} | rsp_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i], i);
        end

        // R8: a read shown during reset leaves no history behind
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_size  = 2'b10;
        req_addr  = 12'h000;
        @(negedge clk);
        rst_n     = 1'b1;
        req_write = 1'b1;
        req_size  = 2'b00;
        req_addr  = 12'h001;
        req_wdata = 32'h0000EE00;
        #1;
        chk(rsp_ready == 1'b1, "R8 narrow write right after reset",
            {31'h0, rsp_ready}, 32'h1);
        if (!rsp_ready) begin
            @(negedge clk);
        end
        @(posedge clk);
        do_req('{1'b0,1'b0,2'b10,12'h000,32'h0,3'd0,1'b0,32'h7733EE99,4'd8}, 99);

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(rsp_rdata == 32'h0 && rsp_ready == 1'b0, "R7 final idle",
            rsp_rdata, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule